// File: doc/BRIEF.md
# Vector Lane Shuffle Permute Unit

This block rearranges the elements of one 512-bit source vector into a 512-bit result, and each result lane picks its source on its own. In word mode the vector is sixteen 32-bit lanes. Result lane i copies the source word at position (start + offset_i) mod 16. The offset of each lane is a 4-bit field taken from one of two 32-bit offset words.

In half mode the same 512 bits are read as thirty-two 16-bit values. The offset fields work in pairs. The first field of a pair names an absolute word. The second field names a word relative to the word after the first one. The two gathered words give four 16-bit values. A square word then picks, for each of the four result positions of that group, which of the four gathered values goes there. The main gather therefore always moves whole 32-bit words, and only the square stage works at 16-bit granularity.

The result is registered. It appears one cycle after a valid strobe and stays unchanged until the next strobe.

Top module: `lane_shuffle_unit`

## Requirements
- R1: In word mode (mode_half=0), result word i (bits 32i+31..32i) equals source word ((start + off_i) mod 16).
- R2: off_i is nibble i of the 64-bit value {offs_hi, offs_lo}. Lanes 0 to 7 come from offs_lo and lanes 8 to 15 from offs_hi, with lane 0 in bits 3..0 of offs_lo.
- R3: Only start[3:0] takes part, so the index wraps modulo 16. A start of 5'h1F acts as -1 and a start of 5'h14 acts as 4.
- R4: In half mode, group p (p = 0..7) gathers word w0 = (start + off_2p) mod 16 and word w1 = (start + off_2p + 1 + off_2p+1) mod 16. The pair 0x24 in the lowest byte therefore gathers 16-bit elements 8,9 and 14,15.
- R5: In half mode, the gathered values are v0 = low half of w0, v1 = high half of w0, v2 = low half of w1 and v3 = high half of w1. Result element 4p+j equals v[q_j], where q_j is square[4j+1:4j] and bits 4j+3:4j+2 are ignored. So 0x2103 gives the order 3,0,1,2.
- R6: In word mode the square input has no effect on the result.
- R7: out_valid is high in exactly the cycle after a cycle in which in_valid was high.
- R8: While in_valid is low, out_vec keeps its last value whatever the other inputs do.
- R9: Synchronous active-low reset clears out_valid and out_vec, and it wins over in_valid.
- R10: Word mode with start 0 and offsets 0xECA86420 (low) and 0xFDB97531 (high) puts even-indexed words in lanes 0 to 7 and odd-indexed words in lanes 8 to 15.
- R11: Half mode with start 0, offsets 0x73727170 and 0x77767574 and square 0x3120 interleaves elements 0 to 15 with elements 16 to 31, element 0 first: 0,16,1,17,...

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Loads a new result at the next edge |
| src_vec | input | 512 | Source vector, word 0 in the low bits |
| start | input | 5 | Base index added to every lane offset |
| offs_lo | input | 32 | Offset nibbles for lanes 0 to 7 |
| offs_hi | input | 32 | Offset nibbles for lanes 8 to 15 |
| square | input | 16 | Per-group 16-bit rearrangement, half mode only |
| mode_half | input | 1 | 0 = 32-bit word mode, 1 = 16-bit mode |
| out_valid | output | 1 | Result valid strobe |
| out_vec | output | 512 | Registered permuted vector |

## Verification
A wrong index sum or a wrong offset nibble shows up as a misplaced word in the result, one cycle after the strobe that caused it. Because every source element in the stimulus carries a unique value, a wrong select also names the element it came from. A fault in the relative second offset of a pair, or in the square decode, corrupts only the half-mode results. A fault in the register enable shows up as a changed result in a cycle with no strobe.

// File: rtl/lane_shuffle_pkg.sv
// Shared sizes and mode encoding for the lane shuffle unit.
// Assumes an even lane count and 16-bit halves inside each 32-bit word.
package lane_shuffle_pkg;
    localparam int unsigned LANES   = 16;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned HALF_W  = WORD_W / 2;
    localparam int unsigned IDX_W   = $clog2(LANES);
    localparam int unsigned START_W = IDX_W + 1;
    localparam int unsigned VEC_W   = LANES * WORD_W;
    localparam int unsigned OFFW_W  = LANES * IDX_W / 2;
    localparam int unsigned GROUPS  = LANES / 2;
    localparam int unsigned SQ_W    = 16;

    typedef enum logic {
        MODE_WORD = 1'b0,
        MODE_HALF = 1'b1
    } shuf_mode_e;
endpackage

// File: rtl/lane_shuffle_gather.sv
// Word gather stage: each result word selects one whole source word.
// In word mode the index is start + own nibble. In half mode an odd lane's
// index is the partner's index + 1 + own nibble. The sum wraps at LANES.
module lane_shuffle_gather
    import lane_shuffle_pkg::*;
#(
    parameter int unsigned N_LANES = LANES,
    parameter int unsigned W_BITS  = WORD_W,
    localparam int unsigned IW     = $clog2(N_LANES)
) (
    input  logic [N_LANES*W_BITS-1:0] src,
    input  logic [IW-1:0]             base,
    input  logic [N_LANES*IW-1:0]     offs,
    input  logic                      half,
    output logic [N_LANES*W_BITS-1:0] gathered
);
    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [IW-1:0] idx;
        if (i % 2 == 0) begin : g_even
            // even lane: absolute index in both modes
            always_comb idx = base + offs[i*IW +: IW];
        end else begin : g_odd
            // odd lane: independent in word mode, partner-relative in half mode
            always_comb begin
                if (half)
                    idx = base + offs[(i-1)*IW +: IW] + IW'(1) + offs[i*IW +: IW];
                else
                    idx = base + offs[i*IW +: IW];
            end
        end
        // word multiplexer for this lane
        always_comb gathered[i*W_BITS +: W_BITS] = src[idx*W_BITS +: W_BITS];
    end
endmodule

// File: rtl/lane_shuffle_twiddle.sv
// Square stage: inside each group of four 16-bit values (two gathered words),
// result position j takes value square[4j+1:4j]. Passes data through unchanged
// in word mode. The upper two bits of each square nibble are ignored.
module lane_shuffle_twiddle
    import lane_shuffle_pkg::*;
#(
    parameter int unsigned N_GROUPS = GROUPS,
    parameter int unsigned H_BITS   = HALF_W
) (
    input  logic [N_GROUPS*4*H_BITS-1:0] din,
    input  logic [15:0]                  square,
    input  logic                         half,
    output logic [N_GROUPS*4*H_BITS-1:0] dout
);
    logic [7:0] sq_unused;

    for (genvar j = 0; j < 4; j++) begin : g_sink
        assign sq_unused[2*j +: 2] = square[4*j+2 +: 2];
    end

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic [H_BITS-1:0] v [4];
        // split the group into its four 16-bit values
        always_comb begin
            for (int k = 0; k < 4; k++)
                v[k] = din[(4*g+k)*H_BITS +: H_BITS];
        end
        for (genvar j = 0; j < 4; j++) begin : g_pos
            // pick gathered value or pass-through for position j
            always_comb begin
                if (half)
                    dout[(4*g+j)*H_BITS +: H_BITS] = v[square[4*j +: 2]];
                else
                    dout[(4*g+j)*H_BITS +: H_BITS] = v[j];
            end
        end
    end
endmodule

// File: rtl/lane_shuffle_unit.sv
// Top of the lane shuffle unit: word gather, optional 16-bit square stage,
// and an output register loaded on in_valid. Assumes the default sizes from
// lane_shuffle_pkg; start keeps only its low IDX_W bits (modulo LANES).
module lane_shuffle_unit
    import lane_shuffle_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [START_W-1:0] start,
    input  logic [OFFW_W-1:0]  offs_lo,
    input  logic [OFFW_W-1:0]  offs_hi,
    input  logic [SQ_W-1:0]    square,
    input  logic               mode_half,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_vec
);
    shuf_mode_e         mode;
    logic [VEC_W-1:0]   gathered;
    logic [VEC_W-1:0]   permuted;
    logic               start_unused;

    assign mode         = shuf_mode_e'(mode_half);
    assign start_unused = start[START_W-1];

    lane_shuffle_gather #(
        .N_LANES (LANES),
        .W_BITS  (WORD_W)
    ) u_gather (
        .src      (src_vec),
        .base     (start[IDX_W-1:0]),
        .offs     ({offs_hi, offs_lo}),
        .half     (mode == MODE_HALF),
        .gathered (gathered)
    );

    lane_shuffle_twiddle #(
        .N_GROUPS (GROUPS),
        .H_BITS   (HALF_W)
    ) u_twiddle (
        .din    (gathered),
        .square (square),
        .half   (mode == MODE_HALF),
        .dout   (permuted)
    );

    // result register: reset clears, strobe loads, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_vec <= permuted;
        end
    end
endmodule

// File: rtl/lane_shuffle_chk.sv
// Property checker for lane_shuffle_unit, attached by bind below.
// Assumes the default sizes (16 lanes of 32 bits).
module lane_shuffle_chk
    import lane_shuffle_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [VEC_W-1:0]   src_vec,
    input logic [START_W-1:0] start,
    input logic [OFFW_W-1:0]  offs_lo,
    input logic [OFFW_W-1:0]  offs_hi,
    input logic [SQ_W-1:0]    square,
    input logic               mode_half,
    input logic               out_valid,
    input logic [VEC_W-1:0]   out_vec
);
    logic [IDX_W-1:0]  lane0_idx;
    logic [WORD_W-1:0] lane0_exp;
    logic              ident_half;
    logic              chk_unused;

    assign chk_unused = ^start[START_W-1];
    // independent expectation for lane 0 in word mode
    assign lane0_idx  = start[IDX_W-1:0] + offs_lo[IDX_W-1:0];
    assign lane0_exp  = src_vec[lane0_idx*WORD_W +: WORD_W];
    // half-mode stimulus that must reproduce the source unchanged
    assign ident_half = mode_half && (start[IDX_W-1:0] == '0) &&
                        (offs_lo == 32'h0604_0200) && (offs_hi == 32'h0E0C_0A08) &&
                        (square == 16'h3210);

    p_valid_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec));

    p_word_lane0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_half) |=> (out_vec[WORD_W-1:0] == $past(lane0_exp)));

    p_half_ident_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ident_half) |=> (out_vec == $past(src_vec)));
endmodule

bind lane_shuffle_unit lane_shuffle_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_vec   (src_vec),
    .start     (start),
    .offs_lo   (offs_lo),
    .offs_hi   (offs_hi),
    .square    (square),
    .mode_half (mode_half),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/lane_shuffle_unit_tb.sv
module lane_shuffle_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [511:0] src_vec;
    logic [4:0]   start;
    logic [31:0]  offs_lo, offs_hi;
    logic [15:0]  square;
    logic         mode_half;
    logic         out_valid;
    logic [511:0] out_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lane_shuffle_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .start(start), .offs_lo(offs_lo), .offs_hi(offs_hi), .square(square),
        .mode_half(mode_half), .out_valid(out_valid), .out_vec(out_vec)
    );

    typedef struct packed {
        logic        half;
        logic [4:0]  st;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [15:0] sq;
        logic [7:0]  seed;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 5'h00, 32'h76543210, 32'hFEDCBA98, 16'h0000, 8'h11, 4'd1},  // R1 identity
        '{1'b0, 5'h00, 32'hECA86420, 32'hFDB97531, 16'h0000, 8'h22, 4'd10}, // R10 even/odd split
        '{1'b0, 5'h03, 32'h01234567, 32'h89ABCDEF, 16'h1234, 8'h33, 4'd2},  // R2 nibble layout, R6 square ignored
        '{1'b0, 5'h1F, 32'h11111111, 32'h00000000, 16'h0000, 8'h44, 4'd3},  // R3 negative start
        '{1'b0, 5'h14, 32'hFFFFFFFF, 32'h5A5A5A5A, 16'hFFFF, 8'h55, 4'd3},  // R3 large start
        '{1'b1, 5'h00, 32'h06040200, 32'h0E0C0A08, 16'h3210, 8'h66, 4'd4},  // R4 identity
        '{1'b1, 5'h00, 32'h73727170, 32'h77767574, 16'h3120, 8'h77, 4'd11}, // R11 interleave
        '{1'b1, 5'h00, 32'h00000024, 32'h00000000, 16'h3210, 8'h88, 4'd4},  // R4 pair 0x24
        '{1'b1, 5'h02, 32'h5A3C9E17, 32'h0F1E2D3C, 16'h2103, 8'h99, 4'd5},  // R5 twiddle 0x2103
        '{1'b1, 5'h1E, 32'hFFFFFFFF, 32'h13579BDF, 16'hCCC0, 8'hAA, 4'd5}   // R5 upper bits ignored
    };

    // source where 16-bit element e holds {seed, e}
    function automatic logic [511:0] mk_src(input logic [7:0] seed);
        logic [511:0] r;
        for (int e = 0; e < 32; e++) r[e*16 +: 16] = {seed, 8'(e)};
        return r;
    endfunction

    // reference result computed from the requirements
    function automatic logic [511:0] model(input logic half, input logic [4:0] st,
            input logic [31:0] lo, input logic [31:0] hi, input logic [15:0] sq,
            input logic [511:0] src);
        logic [63:0]  offs;
        logic [511:0] r;
        logic [15:0]  v [4];
        offs = {hi, lo};
        for (int p = 0; p < 8; p++) begin
            int n0, n1, w0, w1;
            n0 = int'(offs[8*p +: 4]);
            n1 = int'(offs[8*p+4 +: 4]);
            if (!half) begin
                r[64*p +: 32]    = src[((int'(st[3:0]) + n0) % 16)*32 +: 32];
                r[64*p+32 +: 32] = src[((int'(st[3:0]) + n1) % 16)*32 +: 32];
            end else begin
                w0 = (int'(st[3:0]) + n0) % 16;
                w1 = (int'(st[3:0]) + n0 + 1 + n1) % 16;
                v[0] = src[w0*32 +: 16];
                v[1] = src[w0*32+16 +: 16];
                v[2] = src[w1*32 +: 16];
                v[3] = src[w1*32+16 +: 16];
                for (int j = 0; j < 4; j++)
                    r[(4*p+j)*16 +: 16] = v[int'(sq[4*j +: 2])];
            end
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [511:0] act,
            input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid  = 1'b1;
        mode_half = v.half;
        start     = v.st;
        offs_lo   = v.lo;
        offs_hi   = v.hi;
        square    = v.sq;
        src_vec   = mk_src(v.seed);
    endtask

    initial begin
        logic [511:0] exp;
        logic [511:0] held;
        rst_n = 1'b0;
        drive(TBL[0]);                     // strobe during reset must not load
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 valid", 512'(out_valid), 512'd0);
        chk(out_vec == '0, "R9 data", out_vec, '0);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        for (int n = 0; n < NV; n++) begin
            drive(TBL[n]);
            exp = model(TBL[n].half, TBL[n].st, TBL[n].lo, TBL[n].hi, TBL[n].sq, src_vec);
            @(negedge clk);
            in_valid = 1'b0;
            chk(out_vec == exp, $sformatf("R%0d vector %0d", TBL[n].req, n), out_vec, exp);
        end

        // R7: strobe visible one cycle, then cleared
        drive(TBL[2]);
        exp = model(TBL[2].half, TBL[2].st, TBL[2].lo, TBL[2].hi, TBL[2].sq, src_vec);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R7 valid high", 512'(out_valid), 512'd1);
        held = out_vec;
        // R8: inputs change without strobe
        src_vec   = mk_src(8'hEE);
        start     = 5'h07;
        mode_half = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 valid low", 512'(out_valid), 512'd0);
        chk(out_vec == held, "R8 hold", out_vec, held);

        // R6: word mode, two different squares, same result
        drive(TBL[3]);
        square = 16'h1B1B;
        exp = model(1'b0, TBL[3].st, TBL[3].lo, TBL[3].hi, 16'h0000, src_vec);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_vec == exp, "R6 square ignored", out_vec, exp);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule